// File: doc/BRIEF.md
# Store Buffer Commit-Time Model

This block tracks how long a store buffer delays a processor, without holding any store data. Each entry in a ring records how many cycles its store still needs before it reaches memory. A store event adds an entry. A load event makes the core wait until every pending store has committed. A cycle counter input tells the block how much time has passed between events. The block reports the current number of entries, the total stall cycles charged to the core, and the total cost of all stores accepted.

Each accepted event first works out how many cycles have passed since the reference time. It then retires entries from the head, one step per clock, for as long as the elapsed time covers them. Any time left over is taken off the head entry's remaining cost. Next, a store forces out the head if the buffer is at its configured length, and then appends its own cost. A load instead drains every entry. All forced or drained cost is added to the stall total and moves the reference time forward. While this work runs, `busy` is high and new events are ignored.

Top module: `store_buffer_timer`

## Requirements
- R1: While rst_n is low, and after it rises, occupancy, stall_total and store_total read 0, busy is low, and the reference time is 0.
- R2: An accepted store (ev_is_load=0) appends an entry holding ev_cost, raises occupancy by one (less any forced removal, see R6) and adds ev_cost to store_total.
- R3: On an accepted event, elapsed = cycle_now minus the reference time. Head entries are retired oldest first while elapsed is at least the head's remaining cost, and each retired cost is subtracted from elapsed. An entry whose cost exactly equals the elapsed time is retired.
- R4: If entries remain once retirement stops, the head's remaining cost is reduced by the leftover elapsed time.
- R5: If cycle_now is below the reference time, elapsed is 0, and the reference time stays at the larger of the two values.
- R6: On a store, if occupancy is at or above cfg_len, exactly one head entry is forced out before the append. Its remaining cost is added both to stall_total and to the reference time.
- R7: A load (ev_is_load=1) drains every entry. Each remaining cost is added to stall_total and to the reference time, and occupancy ends at 0.
- R8: An event is accepted only when ev_valid is high and busy is low. busy is high from the cycle after acceptance until processing ends, and ev_valid pulses while busy have no effect.
- R9: The ring holds DEPTH entries, and its pointers wrap modulo DEPTH, so occupancy can reach DEPTH when cfg_len equals DEPTH.
- R10: If cfg_len is lowered below the current occupancy, each store still forces out only one entry, so occupancy stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_now | input | CW | Current cycle count |
| ev_valid | input | 1 | Event request |
| ev_is_load | input | 1 | 1 = load event, 0 = store event |
| ev_cost | input | CCW | Commit cost of a store, in cycles |
| cfg_len | input | $clog2(DEPTH+1) | Configured buffer length, 1..DEPTH |
| busy | output | 1 | Event being processed; new requests ignored |
| occupancy | output | $clog2(DEPTH+1) | Entries currently held |
| stall_total | output | TW | Accumulated stall cycles |
| store_total | output | TW | Accumulated cost of all stores |

## Verification
A corrupted remaining cost or reference time does not show at once. It shows at the next load, or at the next forced removal, where stall_total comes out wrong by exactly the error. The bench therefore ends each scenario with a load, which turns every remaining cost into a visible stall increment. A pointer or occupancy fault shows as a wrong occupancy value as soon as the event that caused it completes, and as wrong drained costs after a wrap.

// File: rtl/store_buffer_timer.sv
module store_buffer_timer #(
  parameter int DEPTH = 8,
  parameter int CW    = 32,
  parameter int CCW   = 8,
  parameter int TW    = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cycle_now,
  input  logic           ev_valid,
  input  logic           ev_is_load,
  input  logic [CCW-1:0] ev_cost,
  input  logic [LW-1:0]  cfg_len,
  output logic           busy,
  output logic [LW-1:0]  occupancy,
  output logic [TW-1:0]  stall_total,
  output logic [TW-1:0]  store_total
);

  typedef enum logic [1:0] {S_IDLE, S_RETIRE, S_PUSH, S_DRAIN} state_t;

  state_t         state;
  logic [CCW-1:0] slot [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [LW-1:0]  count;
  logic [CW-1:0]  ref_time, elapsed;
  logic [CCW-1:0] cost_q;
  logic           load_q;

  logic [CCW-1:0] head;
  logic           nonempty, covers, force_out, ahead;

  assign head      = slot[rd_ptr];
  assign nonempty  = count != '0;
  assign covers    = elapsed >= CW'(head);
  assign force_out = nonempty && (count >= cfg_len);
  assign ahead     = cycle_now > ref_time;
  assign busy      = state != S_IDLE;
  assign occupancy = count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rd_ptr      <= '0;
      wr_ptr      <= '0;
      count       <= '0;
      ref_time    <= '0;
      elapsed     <= '0;
      cost_q      <= '0;
      load_q      <= 1'b0;
      stall_total <= '0;
      store_total <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (ev_valid) begin
          elapsed  <= ahead ? cycle_now - ref_time : '0;
          ref_time <= ahead ? cycle_now : ref_time;
          cost_q   <= ev_cost;
          load_q   <= ev_is_load;
          state    <= S_RETIRE;
        end
        S_RETIRE: begin
          if (nonempty && covers) begin
            elapsed <= elapsed - CW'(head);
            rd_ptr  <= nxt(rd_ptr);
            count   <= count - 1'b1;
          end else begin
            if (nonempty) slot[rd_ptr] <= head - CCW'(elapsed);
            state <= load_q ? S_DRAIN : S_PUSH;
          end
        end
        S_PUSH: begin
          if (force_out) begin
            stall_total <= stall_total + TW'(head);
            ref_time    <= ref_time + CW'(head);
            rd_ptr      <= nxt(rd_ptr);
          end
          slot[wr_ptr] <= cost_q;
          wr_ptr       <= nxt(wr_ptr);
          count        <= force_out ? count : count + 1'b1;
          store_total  <= store_total + TW'(cost_q);
          state        <= S_IDLE;
        end
        S_DRAIN: begin
          if (nonempty) begin
            stall_total <= stall_total + TW'(head);
            ref_time    <= ref_time + CW'(head);
            rd_ptr      <= nxt(rd_ptr);
            count       <= count - 1'b1;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module store_buffer_timer_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_is_load,
  input logic          busy,
  input logic [LW-1:0] occupancy,
  input logic [TW-1:0] stall_total,
  input logic [TW-1:0] store_total
);

  logic kind_load;
  always_ff @(posedge clk) begin
    if (!rst_n) kind_load <= 1'b0;
    else if (ev_valid && !busy) kind_load <= ev_is_load;
  end

  // R9
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= LW'(DEPTH));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ev_valid) |=> ($stable(stall_total) && $stable(store_total) && $stable(occupancy)));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ev_valid) |=> busy);

  // R7
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && kind_load) |-> occupancy == '0);

  // R2
  store_leaves_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !kind_load) |-> occupancy != '0);

  // R6
  stall_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_total >= $past(stall_total));

  // R2
  store_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_total >= $past(store_total));

endmodule

bind store_buffer_timer store_buffer_timer_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (.*);

// File: tb/store_buffer_timer_tb.sv
module store_buffer_timer_tb;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cycle_now = '0;
  logic        ev_valid = 1'b0;
  logic        ev_is_load = 1'b0;
  logic [7:0]  ev_cost = '0;
  logic [LW-1:0] cfg_len = LW'(4);
  logic        busy;
  logic [LW-1:0] occupancy;
  logic [31:0] stall_total, store_total;

  int vectors = 0;
  int errors = 0;

  always #4 clk = ~clk;

  store_buffer_timer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now), .ev_valid(ev_valid),
    .ev_is_load(ev_is_load), .ev_cost(ev_cost), .cfg_len(cfg_len),
    .busy(busy), .occupancy(occupancy), .stall_total(stall_total),
    .store_total(store_total));

  task automatic chk(input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send(input logic is_load, input int cost, input int t);
    @(negedge clk);
    cycle_now = t; ev_is_load = is_load; ev_cost = 8'(cost); ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic state_is(input string tag, input int occ, input int stall, input int stores);
    chk({tag, " occupancy"}, occupancy, occ);
    chk({tag, " stall_total"}, stall_total, stall);
    chk({tag, " store_total"}, store_total, stores);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    state_is("R1 in reset", 0, 0, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    state_is("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_elapsed;
    cfg_len = LW'(4);
    send(0, 10, 0);
    state_is("R2 first store", 1, 0, 10);
    send(0, 5, 3);
    state_is("R2 second store", 2, 0, 15);
    send(0, 6, 12);
    state_is("R3 retire one", 2, 0, 21);
    send(1, 0, 13);
    state_is("R4 R7 drain of reduced head", 0, 8, 21);
  endtask

  task automatic t_behind;
    send(0, 4, 15);
    state_is("R5 store behind ref", 1, 8, 25);
    send(1, 0, 21);
    state_is("R5 load at ref", 0, 12, 25);
  endtask

  task automatic t_full;
    cfg_len = LW'(2);
    send(0, 9, 30);
    send(0, 9, 30);
    state_is("R6 filled to len", 2, 12, 43);
    send(0, 9, 30);
    state_is("R6 forced out", 2, 21, 52);
    send(0, 1, 40);
    state_is("R6 forced reduced head", 2, 29, 53);
    send(1, 0, 48);
    state_is("R6 R7 drain after forcing", 0, 39, 53);
  endtask

  task automatic t_exact;
    cfg_len = LW'(8);
    send(0, 2, 60);
    send(0, 3, 60);
    send(0, 4, 60);
    send(0, 1, 65);
    state_is("R3 exact-equal retire", 2, 39, 63);
    send(1, 0, 66);
    state_is("R4 R7 drain", 0, 43, 63);
  endtask

  task automatic t_wrap;
    cfg_len = LW'(8);
    for (int i = 0; i < DEPTH; i++) send(0, 1, 70);
    state_is("R9 full depth", DEPTH, 43, 71);
    send(0, 1, 70);
    state_is("R9 R6 force at depth", DEPTH, 44, 72);
    send(1, 0, 71);
    state_is("R9 drain after wrap", 0, 52, 72);
  endtask

  task automatic t_all_elapsed;
    send(0, 5, 80);
    send(1, 0, 200);
    state_is("R3 all retired by time", 0, 52, 77);
  endtask

  task automatic t_shrink;
    cfg_len = LW'(4);
    for (int i = 0; i < 4; i++) send(0, 1, 200);
    cfg_len = LW'(2);
    send(0, 1, 200);
    state_is("R10 single force", 4, 53, 82);
    send(1, 0, 201);
    state_is("R10 drain", 0, 57, 82);
  endtask

  task automatic t_busy_ignore;
    cfg_len = LW'(4);
    @(negedge clk);
    cycle_now = 300; ev_is_load = 1'b0; ev_cost = 8'd3; ev_valid = 1'b1;
    @(negedge clk);
    chk("R8 busy after accept", busy, 1);
    ev_cost = 8'd50;
    @(negedge clk);
    ev_valid = 1'b0;
    while (busy) @(negedge clk);
    state_is("R8 request during busy ignored", 1, 57, 85);
    send(1, 0, 300);
    state_is("R8 drain", 0, 60, 85);
  endtask

  initial begin
    t_reset;
    t_elapsed;
    t_behind;
    t_full;
    t_exact;
    t_wrap;
    t_all_elapsed;
    t_shrink;
    t_busy_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL R8 watchdog busy actual=%0d expected=0", busy);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule